// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This block compares two floating-point operands and records the one-bit result in one of eight condition bits. The condition bits live inside a 32-bit floating-point control/status word. Operands may be single precision, double precision, or a paired-single word that holds two independent single-precision lanes. The relation tested is chosen by a 4-bit predicate code. The low three bits of that code each enable one term: unordered, equal or less-than. The result is the OR of the enabled terms.

A second, combinational read port serves conditional-move and branch logic. It returns the condition bit at a chosen index and says whether that bit matches a requested polarity. It gives the same answer for the next bit up, which gates the second lane of a paired move. The whole status word can also be loaded in one step. A compare issued in the same cycle as a load still wins for the condition bits it writes.

Top module: `fpcc_unit`

## Requirements
- R1: After a synchronous active-low reset, `fcsr_o` and `cc_o` are all zero.
- R2: Predicate bit 0 enables the unordered term, bit 1 the equal term and bit 2 the less-than term (operand A less than operand B). The result is the OR of the enabled terms, so a code with low bits 000 always gives 0.
- R3: Predicate bit 3 (the signaling variant) has no effect on the result: codes p and p+8 give the same condition bit.
- R4: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. If either operand is a NaN, the equal and less-than terms are 0 and only the unordered term can give 1. Infinities are ordered values.
- R5: Positive and negative zero compare equal and neither is less than the other. Any negative nonzero value is less than any positive value. Between two negatives, the one of larger magnitude is less.
- R6: `fmt_i` encoding: 0 compares single precision on bits [31:0]; 1 compares double precision on bits [63:0]; 2 selects paired single; 3 is reserved, and a start with it leaves the status word unchanged.
- R7: In paired mode the low lane (bits [31:0]) is written to condition bit idx+1 and the high lane (bits [63:32]) to condition bit idx. The index arithmetic wraps modulo 8, so idx 7 puts the low lane in bit 0.
- R8: Condition bit 0 is stored at status bit 23 and condition bit k (1 to 7) at status bit 24+k. `cc_o[k]` shows condition bit k.
- R9: A start sampled at a rising edge updates the status word at that edge, so the new value is visible in the following cycle and not before. A compare changes no status bit outside the addressed condition bits. With no start and no load, the word holds its value.
- R10: A load (`ld_i`) replaces the whole status word with `ld_data_i`. If a start occurs in the same cycle, the condition bits written by the compare take the compare result and all other bits take the load data.
- R11: `cond_o` equals condition bit `rd_idx_i`. `take_o` is 1 when that bit equals `pol_i`; it serves branches and the first lane of a paired move. `take_pair_o` is 1 when bit `rd_idx_i`+1 (mod 8) equals `pol_i`; it serves the second lane of a paired move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Perform a compare in this cycle |
| fmt_i | input | 2 | Operand format (0 single, 1 double, 2 paired, 3 reserved) |
| pred_i | input | 4 | Predicate code |
| cc_idx_i | input | 3 | Condition bit index written by the compare |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| ld_i | input | 1 | Load the whole status word |
| ld_data_i | input | 32 | Value loaded into the status word |
| rd_idx_i | input | 3 | Condition bit index for the read port |
| pol_i | input | 1 | Requested polarity (0 if-false, 1 if-true) |
| fcsr_o | output | 32 | Current status word |
| cc_o | output | 8 | Current condition bits |
| cond_o | output | 1 | Condition bit at `rd_idx_i` |
| take_o | output | 1 | Bit at `rd_idx_i` matches `pol_i` |
| take_pair_o | output | 1 | Bit at `rd_idx_i`+1 matches `pol_i` |

## Verification
The only state is the status word, so a fault appears at `fcsr_o` in the cycle after the compare or load that caused it. A comparator fault shows as one wrong condition bit. A lane or index swap shows as a result in the neighbouring condition bit. A misplaced bit shows outside the 23/25..31 positions. Every write is followed by a check of the full word and of the read port at a random index and polarity, so a wrong bit is reported in the cycle it first becomes visible. Directed cases cover signed zeros, NaN against infinity, wrap of the paired index and the load/compare collision.

// File: rtl/fpcc_pkg.sv
// Package: shared types and the placement of condition bits in the status word.
// Assumes a 32-bit status word with eight condition bits.
package fpcc_pkg;

    localparam int CC_N  = 8;
    localparam int CC_IW = $clog2(CC_N);
    localparam int CSR_W = 32;

    typedef enum logic [1:0] {
        FMT_SGL  = 2'd0,
        FMT_DBL  = 2'd1,
        FMT_PAIR = 2'd2,
        FMT_RSV  = 2'd3
    } fmt_e;

    // Outcome of one ordered/unordered comparison.
    typedef struct packed {
        logic unord;
        logic eq;
        logic lt;
    } rel_t;

    // Status bit that holds condition bit k.
    function automatic int cc_pos(input int k);
        return (k == 0) ? 23 : 24 + k;
    endfunction

    // Mask of all status bits that hold condition bits.
    function automatic logic [CSR_W-1:0] cc_field_mask();
        logic [CSR_W-1:0] m;
        m = '0;
        for (int k = 0; k < CC_N; k++) m[cc_pos(k)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/fpcc_cmp_core.sv
// Module: fpcc_cmp_core
// Compares two IEEE-style values of one precision and evaluates a predicate.
// Assumes: the predicate's low three bits enable unordered, equal, less-than.
// Signed zeros compare equal; a NaN makes the pair unordered.
module fpcc_cmp_core
    import fpcc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   pred_i,
    output rel_t         rel_o,
    output logic         hit_o
);

    logic              sgn_a, sgn_b;
    logic [EXP_W-1:0]  exp_a, exp_b;
    logic [FRAC_W-1:0] frc_a, frc_b;
    logic [W-2:0]      mag_a, mag_b;
    logic              nan_a, nan_b, zero_both;
    logic              mag_lt, mag_gt, lt_raw, eq_raw;

    // Split both operands into sign, exponent, fraction and magnitude.
    always_comb begin
        {sgn_a, exp_a, frc_a} = a_i;
        {sgn_b, exp_b, frc_b} = b_i;
        mag_a = a_i[W-2:0];
        mag_b = b_i[W-2:0];
    end

    // Classify operands: NaN needs all-ones exponent and a nonzero fraction.
    always_comb begin
        nan_a     = (&exp_a) && (|frc_a);
        nan_b     = (&exp_b) && (|frc_b);
        zero_both = (mag_a == '0) && (mag_b == '0);
    end

    // Ordered relation from sign and magnitude.
    always_comb begin
        mag_lt = mag_a < mag_b;
        mag_gt = mag_a > mag_b;
        eq_raw = zero_both || (a_i == b_i);
        if (zero_both)           lt_raw = 1'b0;
        else if (sgn_a != sgn_b) lt_raw = sgn_a;
        else if (sgn_a)          lt_raw = mag_gt;
        else                     lt_raw = mag_lt;
    end

    // Mask ordered terms under NaN and combine with the predicate.
    always_comb begin
        rel_o.unord = nan_a || nan_b;
        rel_o.eq    = !(nan_a || nan_b) && eq_raw;
        rel_o.lt    = !(nan_a || nan_b) && lt_raw;
        hit_o       = (pred_i[0] && rel_o.unord) ||
                      (pred_i[1] && rel_o.eq)    ||
                      (pred_i[2] && rel_o.lt);
    end

    AST_PRED_NONE_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_i == 3'd0) |-> !hit_o);                                       // R2
    AST_NAN_UNORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((nan_a || nan_b) && !pred_i[0]) |-> !hit_o);                       // R4
    AST_ZERO_PAIR_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_both && pred_i[1]) |-> hit_o);                                // R5

endmodule

// File: rtl/fpcc_csr.sv
// Module: fpcc_csr
// Holds the 32-bit status word. Applies an optional full load, then writes the
// masked condition bits. Assumes the write mask comes from the top-level decode.
module fpcc_csr
    import fpcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [CSR_W-1:0] ld_data_i,
    input  logic [CC_N-1:0]  wr_mask_i,
    input  logic [CC_N-1:0]  wr_val_i,
    output logic [CSR_W-1:0] fcsr_o,
    output logic [CC_N-1:0]  cc_o
);

    localparam logic [CSR_W-1:0] CC_MASK = cc_field_mask();

    logic [CSR_W-1:0] fcsr_q, fcsr_d;

    // Next word: load first, then overlay the addressed condition bits.
    always_comb begin
        fcsr_d = ld_i ? ld_data_i : fcsr_q;
        for (int k = 0; k < CC_N; k++) begin
            if (wr_mask_i[k]) fcsr_d[cc_pos(k)] = wr_val_i[k];
        end
    end

    // Status word register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) fcsr_q <= '0;
        else        fcsr_q <= fcsr_d;
    end

    // Condition bit view gathered from their scattered positions.
    for (genvar g = 0; g < CC_N; g++) begin : g_ccview
        assign cc_o[g] = fcsr_q[cc_pos(g)];
    end

    assign fcsr_o = fcsr_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && wr_mask_i == '0) |=> $stable(fcsr_q));                    // R9
    AST_NONCC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> ((fcsr_q & ~CC_MASK) == ($past(fcsr_q) & ~CC_MASK)));     // R9
    AST_LOAD_NONCC: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> ((fcsr_q & ~CC_MASK) == ($past(ld_data_i) & ~CC_MASK)));   // R10

endmodule

// File: rtl/fpcc_rdport.sv
// Module: fpcc_rdport
// Combinational read port for conditional-move and branch logic. Returns the
// selected condition bit and polarity matches for it and its upper neighbour.
module fpcc_rdport
    import fpcc_pkg::*;
(
    input  logic [CC_N-1:0]  cc_i,
    input  logic [CC_IW-1:0] rd_idx_i,
    input  logic             pol_i,
    output logic             cond_o,
    output logic             take_o,
    output logic             take_pair_o
);

    logic [CC_IW-1:0] idx_up;
    logic             bit_up;

    // Select the addressed bit and its wrapped neighbour, compare to polarity.
    always_comb begin
        idx_up      = rd_idx_i + CC_IW'(1);
        cond_o      = cc_i[rd_idx_i];
        bit_up      = cc_i[idx_up];
        take_o      = ~(cond_o ^ pol_i);
        take_pair_o = ~(bit_up ^ pol_i);
    end

endmodule

// File: rtl/fpcc_unit.sv
// Module: fpcc_unit (top)
// Floating-point compare writing condition bits of the status word.
// Single, double and paired-single formats; paired lanes land in idx and idx+1.
// Assumes operands and controls are stable around the rising edge that samples start_i.
module fpcc_unit
    import fpcc_pkg::*;
#(
    parameter int SP_EXP  = 8,
    parameter int SP_FRAC = 23,
    parameter int DP_EXP  = 11,
    parameter int DP_FRAC = 52,
    localparam int SP_W   = 1 + SP_EXP + SP_FRAC,
    localparam int DP_W   = 1 + DP_EXP + DP_FRAC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       fmt_i,
    input  logic [3:0]       pred_i,
    input  logic [2:0]       cc_idx_i,
    input  logic [DP_W-1:0]  opa_i,
    input  logic [DP_W-1:0]  opb_i,
    input  logic             ld_i,
    input  logic [31:0]      ld_data_i,
    input  logic [2:0]       rd_idx_i,
    input  logic             pol_i,
    output logic [31:0]      fcsr_o,
    output logic [7:0]       cc_o,
    output logic             cond_o,
    output logic             take_o,
    output logic             take_pair_o
);

    localparam int LANES = DP_W / SP_W;

    fmt_e              fmt;
    logic [LANES-1:0]  lane_hit;
    rel_t [LANES-1:0]  lane_rel;
    logic              dbl_hit;
    rel_t              dbl_rel;
    logic [CC_N-1:0]   wr_mask, wr_val;
    logic [CC_IW-1:0]  idx_up;
    logic              sig_unused;

    assign fmt        = fmt_e'(fmt_i);
    assign sig_unused = pred_i[3];   // signaling variant: same condition result

    // Single-precision lane comparators; lane 0 also serves plain single format.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fpcc_cmp_core #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
            .clk    (clk),
            .rst_n  (rst_n),
            .a_i    (opa_i[g*SP_W +: SP_W]),
            .b_i    (opb_i[g*SP_W +: SP_W]),
            .pred_i (pred_i[2:0]),
            .rel_o  (lane_rel[g]),
            .hit_o  (lane_hit[g])
        );
    end

    // Double-precision comparator over the full operand width.
    fpcc_cmp_core #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (opa_i),
        .b_i    (opb_i),
        .pred_i (pred_i[2:0]),
        .rel_o  (dbl_rel),
        .hit_o  (dbl_hit)
    );

    // Decode format into the condition bits to write and their values.
    always_comb begin
        wr_mask = '0;
        wr_val  = '0;
        idx_up  = cc_idx_i + CC_IW'(1);
        if (start_i) begin
            unique case (fmt)
                FMT_SGL: begin
                    wr_mask[cc_idx_i] = 1'b1;
                    wr_val[cc_idx_i]  = lane_hit[0];
                end
                FMT_DBL: begin
                    wr_mask[cc_idx_i] = 1'b1;
                    wr_val[cc_idx_i]  = dbl_hit;
                end
                FMT_PAIR: begin
                    wr_mask[cc_idx_i] = 1'b1;
                    wr_val[cc_idx_i]  = lane_hit[LANES-1];
                    wr_mask[idx_up]   = 1'b1;
                    wr_val[idx_up]    = lane_hit[0];
                end
                default: ;
            endcase
        end
    end

    fpcc_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_i      (ld_i),
        .ld_data_i (ld_data_i),
        .wr_mask_i (wr_mask),
        .wr_val_i  (wr_val),
        .fcsr_o    (fcsr_o),
        .cc_o      (cc_o)
    );

    fpcc_rdport u_rd (
        .cc_i        (cc_o),
        .rd_idx_i    (rd_idx_i),
        .pol_i       (pol_i),
        .cond_o      (cond_o),
        .take_o      (take_o),
        .take_pair_o (take_pair_o)
    );

    AST_RSV_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && fmt_i == 2'd3 && !ld_i) |=> $stable(fcsr_o));           // R6
    AST_SGL_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && fmt_i[1] == 1'b0 && !ld_i)
            |=> ($countones(cc_o ^ $past(cc_o)) <= 1));                      // R8
    AST_PAIR_TWOBITS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && fmt_i == 2'd2 && !ld_i)
            |=> ($countones(cc_o ^ $past(cc_o)) <= 2));                      // R7
    AST_LOAD_SKIP_CC: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && !start_i) |=> (fcsr_o == $past(ld_data_i)));               // R10

endmodule

// File: tb/fpcc_unit_test.sv
`timescale 1ns/1ps
module fpcc_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  fmt_i = '0;
    logic [3:0]  pred_i = '0;
    logic [2:0]  cc_idx_i = '0;
    logic [63:0] opa_i = '0, opb_i = '0;
    logic        ld_i = 1'b0;
    logic [31:0] ld_data_i = '0;
    logic [2:0]  rd_idx_i = '0;
    logic        pol_i = 1'b0;
    logic [31:0] fcsr_o;
    logic [7:0]  cc_o;
    logic        cond_o, take_o, take_pair_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] mdl = '0;

    always #2.5 clk = ~clk;

    fpcc_unit uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Status bit for condition bit k: 23 for k=0, 24+k otherwise (R8).
    function automatic int bpos(input int k);
        return (k == 0) ? 23 : 24 + k;
    endfunction

    function automatic logic mdl_ccbit(input logic [31:0] w, input int k);
        return w[bpos(k)];
    endfunction

    // Reference compare on a field layout of ew exponent and fw fraction bits.
    function automatic logic mdl_cmp(input logic [63:0] a, input logic [63:0] b,
                                     input int ew, input int fw, input logic [3:0] p);
        longint unsigned em, fm, mm;
        longint ka, kb;
        logic na, nb;
        em = (64'd1 << ew) - 1;
        fm = (64'd1 << fw) - 1;
        mm = (64'd1 << (ew + fw)) - 1;
        na = (((a >> fw) & em) == em) && ((a & fm) != 0);
        nb = (((b >> fw) & em) == em) && ((b & fm) != 0);
        ka = a[ew+fw] ? -longint'(a & mm) : longint'(a & mm);
        kb = b[ew+fw] ? -longint'(b & mm) : longint'(b & mm);
        if (na || nb) return p[0];
        return (p[1] && ka == kb) || (p[2] && ka < kb);
    endfunction

    function automatic logic [31:0] rand_sp();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7F80_0000;
            3: return 32'hFF80_0000;
            4: return 32'h7F80_0000 | (($urandom % 32'h7F_FFFF) + 1);
            5: return {1'b0, 8'd127, 23'($urandom % 8)};
            6: return {1'b1, 8'd127, 23'($urandom % 8)};
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [63:0] rand_dp();
        case ($urandom % 8)
            0: return 64'h0;
            1: return 64'h8000_0000_0000_0000;
            2: return 64'h7FF0_0000_0000_0000;
            3: return 64'hFFF0_0000_0000_0000;
            4: return 64'h7FF8_0000_0000_0000 | 64'($urandom);
            5: return {1'b0, 11'd1023, 52'($urandom % 4)};
            6: return {1'b1, 11'd1023, 52'($urandom % 4)};
            default: return {$urandom, $urandom};
        endcase
    endfunction

    // One compare transaction; updates the model and checks word and read port.
    task automatic do_cmp(input logic [1:0] f, input logic [3:0] p, input logic [2:0] idx,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic ld, input logic [31:0] ldd);
        logic [31:0] nxt;
        logic [2:0]  up;
        logic [2:0]  ri;
        logic        pl;
        @(negedge clk);
        fmt_i = f; pred_i = p; cc_idx_i = idx; opa_i = a; opb_i = b;
        ld_i = ld; ld_data_i = ldd; start_i = 1'b1;
        #1;
        chk(fcsr_o == mdl, "R9 no update before edge", 64'(fcsr_o), 64'(mdl));
        nxt = ld ? ldd : mdl;
        up  = idx + 3'd1;
        case (f)
            2'd0: nxt[bpos(idx)] = mdl_cmp(a, b, 8, 23, p);
            2'd1: nxt[bpos(idx)] = mdl_cmp(a, b, 11, 52, p);
            2'd2: begin
                nxt[bpos(idx)] = mdl_cmp({32'h0, a[63:32]}, {32'h0, b[63:32]}, 8, 23, p);
                nxt[bpos(up)]  = mdl_cmp({32'h0, a[31:0]},  {32'h0, b[31:0]},  8, 23, p);
            end
            default: ;
        endcase
        mdl = nxt;
        @(negedge clk);
        start_i = 1'b0; ld_i = 1'b0;
        ri = 3'($urandom); pl = 1'($urandom);
        rd_idx_i = ri; pol_i = pl;
        #1;
        chk(fcsr_o == mdl, "R2/R6/R7/R9 status word", 64'(fcsr_o), 64'(mdl));
        chk(cond_o == mdl_ccbit(mdl, ri), "R11 cond_o", 64'(cond_o), 64'(mdl_ccbit(mdl, ri)));
        chk(take_o == (mdl_ccbit(mdl, ri) == pl), "R11 take_o", 64'(take_o),
            64'(mdl_ccbit(mdl, ri) == pl));
        chk(take_pair_o == (mdl_ccbit(mdl, 3'(ri + 3'd1)) == pl), "R11 take_pair_o",
            64'(take_pair_o), 64'(mdl_ccbit(mdl, 3'(ri + 3'd1)) == pl));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic r_a, r_b;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(fcsr_o == 32'h0, "R1 fcsr reset", 64'(fcsr_o), 64'h0);
        chk(cc_o == 8'h0, "R1 cc reset", 64'(cc_o), 64'h0);

        // R2: 1.0 < 2.0 single, less-than predicate at cc0 -> status bit 23 (R8)
        do_cmp(2'd0, 4'd4, 3'd0, 64'h3F80_0000, 64'h4000_0000, 1'b0, '0);
        chk(fcsr_o[23] == 1'b1, "R2 lt true / R8 cc0 at bit23", 64'(fcsr_o[23]), 64'h1);
        do_cmp(2'd0, 4'd2, 3'd1, 64'h3F80_0000, 64'h4000_0000, 1'b0, '0);
        chk(cc_o[1] == 1'b0, "R2 eq false", 64'(cc_o[1]), 64'h0);
        do_cmp(2'd0, 4'd0, 3'd0, 64'h3F80_0000, 64'h3F80_0000, 1'b0, '0);
        chk(cc_o[0] == 1'b0, "R2 code 0 false", 64'(cc_o[0]), 64'h0);
        // R8: cc1 at status bit 25
        do_cmp(2'd0, 4'd6, 3'd1, 64'h3F80_0000, 64'h3F80_0000, 1'b0, '0);
        chk(fcsr_o[25] == 1'b1 && fcsr_o[24] == 1'b0, "R8 cc1 at bit25", 64'(fcsr_o), 64'h0200_0000);

        // R3: signaling codes give the same result
        for (int p = 0; p < 8; p++) begin
            do_cmp(2'd0, 4'(p), 3'd2, 64'hBF80_0000, 64'h3F80_0000, 1'b0, '0);
            r_a = cc_o[2];
            do_cmp(2'd0, 4'(p + 8), 3'd2, 64'hBF80_0000, 64'h3F80_0000, 1'b0, '0);
            r_b = cc_o[2];
            chk(r_a == r_b, "R3 signaling variant", 64'(r_b), 64'(r_a));
        end

        // R4: NaN vs 1.0 is unordered; inf vs inf is ordered and equal
        do_cmp(2'd0, 4'd6, 3'd3, 64'h7FC0_0000, 64'h3F80_0000, 1'b0, '0);
        chk(cc_o[3] == 1'b0, "R4 NaN ordered terms off", 64'(cc_o[3]), 64'h0);
        do_cmp(2'd0, 4'd1, 3'd3, 64'h7FC0_0000, 64'h3F80_0000, 1'b0, '0);
        chk(cc_o[3] == 1'b1, "R4 NaN unordered", 64'(cc_o[3]), 64'h1);
        do_cmp(2'd1, 4'd3, 3'd4, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1'b0, '0);
        chk(cc_o[4] == 1'b1, "R4 inf equal", 64'(cc_o[4]), 64'h1);
        do_cmp(2'd1, 4'd1, 3'd4, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1'b0, '0);
        chk(cc_o[4] == 1'b0, "R4 inf not unordered", 64'(cc_o[4]), 64'h0);

        // R5: signed zeros and signed ordering
        do_cmp(2'd0, 4'd2, 3'd5, 64'h0000_0000, 64'h8000_0000, 1'b0, '0);
        chk(cc_o[5] == 1'b1, "R5 +0 == -0", 64'(cc_o[5]), 64'h1);
        do_cmp(2'd0, 4'd4, 3'd5, 64'h8000_0000, 64'h0000_0000, 1'b0, '0);
        chk(cc_o[5] == 1'b0, "R5 -0 not < +0", 64'(cc_o[5]), 64'h0);
        do_cmp(2'd0, 4'd4, 3'd6, 64'hC000_0000, 64'hBF80_0000, 1'b0, '0);
        chk(cc_o[6] == 1'b1, "R5 -2 < -1", 64'(cc_o[6]), 64'h1);
        do_cmp(2'd1, 4'd4, 3'd6, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b0, '0);
        chk(cc_o[6] == 1'b0, "R5 2.0 not < 1.0 double", 64'(cc_o[6]), 64'h0);

        // R6: double uses upper bits; reserved format writes nothing
        do_cmp(2'd1, 4'd4, 3'd7, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0, '0);
        chk(cc_o[7] == 1'b1, "R6 double compare", 64'(cc_o[7]), 64'h1);
        do_cmp(2'd3, 4'd0, 3'd7, 64'h0, 64'h0, 1'b0, '0);
        chk(cc_o[7] == 1'b1, "R6 reserved format no write", 64'(cc_o[7]), 64'h1);

        // R7: paired lanes at idx 2 and wrap at idx 7
        do_cmp(2'd2, 4'd4, 3'd2, {32'h4000_0000, 32'h3F80_0000}, {32'h3F80_0000, 32'h4000_0000}, 1'b0, '0);
        chk(cc_o[3] == 1'b1 && cc_o[2] == 1'b0, "R7 paired lanes", 64'(cc_o), 64'(mdl));
        do_cmp(2'd2, 4'd4, 3'd7, {32'h4000_0000, 32'h3F80_0000}, {32'h3F80_0000, 32'h4000_0000}, 1'b0, '0);
        chk(cc_o[0] == 1'b1 && cc_o[7] == 1'b0, "R7 paired wrap", 64'(cc_o), 64'(mdl));

        // R10: load alone, then load colliding with a compare
        do_cmp(2'd3, 4'd0, 3'd0, 64'h0, 64'h0, 1'b1, 32'h5A5A_5A5A);
        chk(fcsr_o == 32'h5A5A_5A5A, "R10 load", 64'(fcsr_o), 64'h5A5A_5A5A);
        do_cmp(2'd0, 4'd2, 3'd0, 64'h3F80_0000, 64'h3F80_0000, 1'b1, 32'h0000_0000);
        chk(fcsr_o == 32'h0080_0000, "R10 compare wins over load", 64'(fcsr_o), 64'h0080_0000);

        // R9: idle cycles hold the word
        repeat (3) @(negedge clk);
        #1;
        chk(fcsr_o == mdl, "R9 idle hold", 64'(fcsr_o), 64'(mdl));

        // Random mix across formats, predicates and indexes
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  f;
            logic [63:0] a, b;
            f = 2'($urandom);
            if (f == 2'd1) begin
                a = rand_dp();
                b = ($urandom % 4 == 0) ? a : rand_dp();
            end else begin
                a = {rand_sp(), rand_sp()};
                b = ($urandom % 4 == 0) ? a : {rand_sp(), rand_sp()};
            end
            do_cmp(f, 4'($urandom), 3'($urandom), a, b,
                   ($urandom % 8 == 0), $urandom);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule